// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory with Mode Decoder

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory together with the control decoding that decides, cycle by cycle, what the device is doing. Its inputs are the active-low chip select and output enable strobes and a digital flag that says the shared output-enable/program-supply pin is at programming voltage. A second flag says that address line 9 carries the high identify voltage. There is also a full-width address bus. The bidirectional data pins are split into a data-in byte, a data-out byte and a drive-enable bit.

The decoder selects one of seven operating states. These are standby, read, output disabled, program, program verify, program inhibit and identify. The state is held in a register and shown on a port. Output data is also registered, so the outputs follow the inputs one clock later. Programming only clears bits. A cell starts at all ones and each programming pulse ANDs the data-in byte into it. The write is committed once, when chip select rises at the end of a low pulse while the supply flag stays high.

In the identify state the block returns one of two fixed bytes, chosen by address bit 0. Each byte has odd parity, with bit 7 as the parity bit. The array depth is a parameter, so a small array can stand in for the full 1M-byte space. The cell index is taken from the low address bits, and the address decode for identify always looks at the full bus.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset, `mode` is STANDBY (code 0), `dout_en` is 0, `dout` is 00h, and every cell reads FFh.
- R2: `mode`, `dout` and `dout_en` are registered: they show the decode of the inputs sampled at the previous rising clock edge and do not change between edges.
- R3: With `ce_n` high and `vpp_hi` low, `mode` becomes STANDBY (code 0) and `dout_en` is 0, whatever `oe_n` is.
- R4: With `ce_n` low, `oe_n` low and `vpp_hi` low, outside a programming session and with no identify request, `mode` becomes READ (code 1) and `dout` drives the cell at index `addr[IDX_W-1:0]`, with `dout_en` 1.
- R5: With `ce_n` low, `oe_n` high and `vpp_hi` low, `mode` becomes OUTPUT_OFF (code 2) and `dout_en` is 0. This state ends a programming session.
- R6: With `vpp_hi` high and `ce_n` low, `mode` becomes PROGRAM (code 3) and `dout_en` is 0. `oe_n` is ignored, and the address and data-in are captured on every PROGRAM cycle.
- R7: Moving from PROGRAM to INHIBIT (`ce_n` rises while `vpp_hi` stays high) writes the captured cell exactly once, as old AND captured data. A pulse that ends because `vpp_hi` drops writes nothing.
- R8: With `vpp_hi` high and `ce_n` high, `mode` becomes INHIBIT (code 5), `dout_en` is 0 and nothing is written.
- R9: Once `vpp_hi` has been high, and until an OUTPUT_OFF state, the read condition of R4 gives VERIFY (code 4), which drives the stored byte.
- R10: With `a9_hv` high and the read condition of R4, when every address bit other than bits 0 and 9 is zero, `mode` becomes IDENTIFY (code 6). `dout` is C2h when `addr[0]`=0 and 80h when `addr[0]`=1. Identify takes priority over READ and VERIFY.
- R11: Both identify bytes have odd parity over bits 7..0, with bit 7 being the parity bit.
- R12: With `a9_hv` high but any address bit other than bits 0 and 9 set, the block gives READ or VERIFY of the array cell instead of an identifier.
- R13: Whenever `dout_en` is 0, `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low; program pulse strobe |
| oe_n | input | 1 | Output enable, active low (shared pin at logic level) |
| vpp_hi | input | 1 | Shared pin is at programming voltage |
| a9_hv | input | 1 | Address line 9 carries the identify voltage |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte driven on the data pins |
| dout_en | output | 1 | Data pins are driven (0 means high impedance) |
| mode | output | 3 | Current state code (see requirements) |

## Verification
The bench builds the block with the full 20-bit address but only 64 cells. Random addresses therefore hit the same cells many times, so repeated programming pulses pile up zeros and the AND-only rule is tested under real overlap. Because the address is full width, identify requests can be spoiled by a stray high bit anywhere from bit 1 to bit 19, and such an address then aliases onto a real cell. That makes the R12 fall-back observable.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_READ    = 3'd1,
        M_OUTOFF  = 3'd2,
        M_PROGRAM = 3'd3,
        M_VERIFY  = 3'd4,
        M_INHIBIT = 3'd5,
        M_IDENT   = 3'd6
    } otp_mode_e;

    // 7-bit identifier payloads; bit 7 is derived as odd parity
    localparam logic [6:0] MAKER_PAYLOAD  = 7'h42;
    localparam logic [6:0] DEVICE_PAYLOAD = 7'h00;

endpackage

// File: rtl/otp_mode_decode.sv
`timescale 1ns/1ps
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              session,
    output otp_mode_e         mode_nx
);
    // bits 0 and 9 may be anything during identify
    localparam logic [ADDR_W-1:0] FREE_BITS =
        {{(ADDR_W-10){1'b0}}, 1'b1, 8'h00, 1'b1};
    localparam logic [ADDR_W-1:0] ZERO_MASK = ~FREE_BITS;

    logic id_addr_ok;

    always_comb begin
        id_addr_ok = a9_hv && ((addr & ZERO_MASK) == '0);
        if (vpp_hi)
            mode_nx = ce_n ? M_INHIBIT : M_PROGRAM;
        else if (ce_n)
            mode_nx = M_STANDBY;
        else if (oe_n)
            mode_nx = M_OUTOFF;
        else if (id_addr_ok)
            mode_nx = M_IDENT;
        else if (session)
            mode_nx = M_VERIFY;
        else
            mode_nx = M_READ;
    end

endmodule

// File: rtl/otp_id_rom.sv
`timescale 1ns/1ps
module otp_id_rom
    import otp_pkg::*;
(
    input  logic       sel_device,
    output logic [7:0] code
);
    localparam logic [7:0] MAKER_CODE  = {~(^MAKER_PAYLOAD),  MAKER_PAYLOAD};
    localparam logic [7:0] DEVICE_CODE = {~(^DEVICE_PAYLOAD), DEVICE_PAYLOAD};

    assign code = sel_device ? DEVICE_CODE : MAKER_CODE;

endmodule

// File: rtl/otp_cell_array.sv
`timescale 1ns/1ps
module otp_cell_array #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] cells [DEPTH];
    logic [7:0] old_byte;

    assign old_byte = cells[waddr];
    assign rdata    = cells[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= old_byte & wdata;
        end
    end

    // R7: a write never raises a bit
    a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((cells[$past(waddr)] & ~$past(old_byte)) == 8'h00));

    // R7: one commit per pulse, never on back-to-back cycles
    a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

endmodule

// File: rtl/otp_byte_mem.sv
`timescale 1ns/1ps
module otp_byte_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [2:0]        mode
);
    otp_mode_e        mode_q, mode_nx;
    logic             session_q;
    logic [IDX_W-1:0] pgm_idx_q;
    logic [7:0]       pgm_data_q;
    logic             commit;
    logic [7:0]       cell_rd;
    logic [7:0]       id_code;

    otp_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .a9_hv   (a9_hv),
        .addr    (addr),
        .session (session_q),
        .mode_nx (mode_nx)
    );

    otp_id_rom u_id (
        .sel_device (addr[0]),
        .code       (id_code)
    );

    // write fires when a pulse closes with supply still high
    assign commit = (mode_q == M_PROGRAM) && (mode_nx == M_INHIBIT);

    otp_cell_array #(.DEPTH(DEPTH)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (pgm_idx_q),
        .wdata (pgm_data_q),
        .raddr (addr[IDX_W-1:0]),
        .rdata (cell_rd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= M_STANDBY;
            session_q  <= 1'b0;
            pgm_idx_q  <= '0;
            pgm_data_q <= 8'hFF;
        end else begin
            mode_q <= mode_nx;
            if (vpp_hi)
                session_q <= 1'b1;
            else if (mode_nx == M_OUTOFF)
                session_q <= 1'b0;
            if (mode_nx == M_PROGRAM) begin
                pgm_idx_q  <= addr[IDX_W-1:0];
                pgm_data_q <= din;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end else begin
            unique case (mode_nx)
                M_READ, M_VERIFY: begin
                    dout    <= cell_rd;
                    dout_en <= 1'b1;
                end
                M_IDENT: begin
                    dout    <= id_code;
                    dout_en <= 1'b1;
                end
                default: begin
                    dout    <= 8'h00;
                    dout_en <= 1'b0;
                end
            endcase
        end
    end

    assign mode = mode_q;

    a_r3_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> (!dout_en && mode == 3'd0));

    a_r5_outoff_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |=> (!dout_en && mode == 3'd2));

    a_r6_program_float: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n) |=> (!dout_en && mode == 3'd3));

    a_r8_inhibit_float: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && ce_n) |=> (!dout_en && mode == 3'd5));

    a_r11_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> (dout_en && (^dout)));

    a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

endmodule

// File: tb/sim_otp_byte_mem.sv
`timescale 1ns/1ps
module sim_otp_byte_mem;
    localparam int AW = 20;
    localparam int DP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic dout_en;
    logic [2:0] mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [DP];
    logic [2:0] m_state;
    logic       m_session;
    logic [5:0] m_pidx;
    logic [7:0] m_pdata;

    always #10 clk = ~clk;

    otp_byte_mem #(.ADDR_W(AW), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .mode(mode)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit id_addr(input logic [AW-1:0] a);
        return (a & ~20'h00201) == '0;
    endfunction

    function automatic logic [2:0] ref_next(input logic ce, oe, vpp, a9,
                                            input logic [AW-1:0] a);
        if (vpp) return ce ? 3'd5 : 3'd3;
        if (ce) return 3'd0;
        if (oe) return 3'd2;
        if (a9 && id_addr(a)) return 3'd6;
        return m_session ? 3'd4 : 3'd1;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3 standby";
            3'd1: return "R4 read";
            3'd2: return "R5 outoff";
            3'd3: return "R6 program";
            3'd4: return "R9 verify";
            3'd5: return "R8 inhibit";
            default: return "R10 identify";
        endcase
    endfunction

    // one cycle: drive at falling edge, check after the rising edge
    task automatic step(input logic ce, oe, vpp, a9,
                        input logic [AW-1:0] a, input logic [7:0] d);
        logic [2:0] nx;
        logic [7:0] ed;
        logic       ee;
        @(negedge clk);
        ce_n = ce; oe_n = oe; vpp_hi = vpp; a9_hv = a9; addr = a; din = d;
        nx = ref_next(ce, oe, vpp, a9, a);
        ee = (nx == 3'd1 || nx == 3'd4 || nx == 3'd6);
        if (nx == 3'd6) ed = a[0] ? 8'h80 : 8'hC2;
        else if (ee) ed = ref_mem[a[5:0]];
        else ed = 8'h00;   // R13
        @(posedge clk);
        #2;
        check({mode, dout_en, dout} === {nx, ee, ed}, tag_of(nx),
              {4'h0, mode, dout_en, dout}, {4'h0, nx, ee, ed});
        if (m_state == 3'd3 && nx == 3'd5)
            ref_mem[m_pidx] = ref_mem[m_pidx] & m_pdata;   // R7
        if (nx == 3'd3) begin m_pidx = a[5:0]; m_pdata = d; end
        if (vpp) m_session = 1'b1;
        else if (nx == 3'd2) m_session = 1'b0;
        m_state = nx;
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input int len);
        for (int i = 0; i < len; i++) step(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        step(1'b1, 1'b1, 1'b1, 1'b0, a, d);
        step(1'b1, 1'b1, 1'b0, 1'b0, a, d);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < DP; i++) ref_mem[i] = 8'hFF;
        m_state = 3'd0; m_session = 1'b0; m_pidx = '0; m_pdata = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check({mode, dout_en, dout} === 12'h000, "R1 reset outputs",
              {4'h0, mode, dout_en, dout}, 16'h0000);
        @(negedge clk) rst_n = 1'b1;

        // R2: output holds until the edge
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = 20'h5;
        #3;
        check(dout_en === 1'b0, "R2 registered delay", {15'h0, dout_en}, 16'h0);
        @(posedge clk); #2;
        check({dout_en, dout} === 9'h1FF, "R1 erased cell / R2 after edge",
              {7'h0, dout_en, dout}, 16'h01FF);
        m_state = 3'd1;

        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 20'(i * 7), 8'h00);

        // R6/R7 program and verify
        pulse(20'h5, 8'h5A, 3);
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'h5, 8'h00);
        check(mode === 3'd4 && dout === 8'h5A, "R9 verify after program",
              {5'h0, mode, dout}, {5'h0, 3'd4, 8'h5A});
        pulse(20'h5, 8'hF0, 1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'h5, 8'h00);
        check(dout === 8'h50, "R7 and-accumulate", {8'h0, dout}, 16'h0050);

        // R5 ends the session
        step(1'b0, 1'b1, 1'b0, 1'b0, 20'h5, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'h5, 8'h00);
        check(mode === 3'd1, "R5 session cleared -> R4 read", {13'h0, mode}, 16'h1);

        // R7 aborted pulse: supply drops first
        step(1'b0, 1'b1, 1'b1, 1'b0, 20'h6, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 20'h6, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 20'h6, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b0, 20'h6, 8'h00);
        check(dout === 8'hFF, "R7 no write on supply drop", {8'h0, dout}, 16'h00FF);

        // R10/R11/R12 identify
        step(1'b0, 1'b0, 1'b0, 1'b1, 20'h00000, 8'h00);
        check(dout === 8'hC2 && (^dout) === 1'b1, "R10 R11 maker code", {8'h0, dout}, 16'h00C2);
        step(1'b0, 1'b0, 1'b0, 1'b1, 20'h00201, 8'h00);
        check(dout === 8'h80 && (^dout) === 1'b1, "R10 R11 device code", {8'h0, dout}, 16'h0080);
        step(1'b0, 1'b0, 1'b0, 1'b1, 20'h80005, 8'h00);
        check(mode === 3'd1 && dout === 8'h50, "R12 stray bit falls back to array",
              {5'h0, mode, dout}, {5'h0, 3'd1, 8'h50});

        // R3 standby ignores oe_n; R8 inhibit ignores oe_n
        step(1'b1, 1'b0, 1'b0, 1'b0, 20'h5, 8'h00);
        check(dout_en === 1'b0 && mode === 3'd0, "R3 standby with oe low",
              {12'h0, mode, dout_en}, 16'h0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 20'h5, 8'h00);
        check(dout_en === 1'b0 && mode === 3'd5, "R8 inhibit with oe low",
              {12'h0, mode, dout_en}, {12'h0, 3'd5, 1'b0});

        // constrained random phase
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] a;
            logic ce, oe, vp, hv;
            ce = ($urandom % 3) == 0;
            oe = ($urandom % 3) == 0;
            vp = ($urandom % 4) == 0;
            hv = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) a = 20'($urandom % 2) | (($urandom % 2) != 0 ? 20'h200 : 20'h0);
            else if (($urandom % 2) == 0) a = 20'($urandom % DP);
            else a = 20'($urandom);
            step(ce, oe, vp, hv, a, 8'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule